// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Symbol Classifier

This block watches the single data line of a variable-pulse-width vehicle network. It measures how long each passive and each active stretch lasts and turns those widths into frame-level symbol events. A once-per-microsecond tick from the system clock paces the measurement. The line level comes through a two-flop synchronizer. Each edge on the synchronized line restarts a saturating width counter. That counter is compared against four fixed thresholds: end of data, end of frame, inter-frame separation complete, and break.

A passive stretch that follows a falling edge first yields end-of-data, then end-of-frame, then separation-complete. If activity resumes early, for example with an in-frame response, the measurement starts again from that edge. The transmitter-facing side has a permission output that is high only once separation has completed and while the line is still passive. An active stretch that grows too long is reported as a break. A break sets a sticky flag, which the host clears. While the flag is set, a local transmission in progress is told to abort.

Top module: `vpw_symbol_timer`

## Requirements
- R1: After reset, all four event pulses, `brk_flag` and `tx_abort` are low, and `tx_permit` is high while the line is passive (line level 1 = active, 0 = passive).
- R2: `eod_pulse` fires on the tick at which a passive stretch that began at a falling edge reaches 200 us.
- R3: `eof_pulse` fires on the tick at which that passive stretch reaches 280 us. A rising edge before then restarts the measurement, so the next passive stretch is timed afresh from its own falling edge.
- R4: `ifs_pulse` fires when the passive stretch reaches 300 us. `tx_permit` is low from the first synchronized active sample until that pulse, and high afterwards while the line stays passive.
- R5: A rising edge that arrives while the block waits for separation to complete restarts timing. The following active stretch is measured from that edge.
- R6: `brk_pulse` fires and `brk_flag` sets on the tick at which an active stretch that began at a rising edge reaches 239 us. An active stretch of 238 us produces neither.
- R7: `brk_flag` stays set through later line changes until a one-cycle `brk_clr`, which clears it on the next clock.
- R8: `tx_abort` is high exactly when `brk_flag` is set, the synchronized line is active and `tx_busy` is high.
- R9: Each event fires at most once per stretch. The width counter saturates, so however long a stretch lasts, no event repeats.
- R10: Until the first line transition after reset, no event fires, whatever number of ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw bus level, 1 = active |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_busy | input | 1 | Local transmitter is sending |
| brk_clr | input | 1 | Host clear of the break flag |
| eod_pulse | output | 1 | End-of-data reached |
| eof_pulse | output | 1 | End-of-frame reached |
| ifs_pulse | output | 1 | Inter-frame separation complete |
| brk_pulse | output | 1 | Break detected |
| brk_flag | output | 1 | Sticky break indication |
| tx_permit | output | 1 | Start of transmission allowed |
| tx_abort | output | 1 | Stop local transmission now |

## Verification
The case that is hardest to reach is a rising edge landing in the window between end-of-frame and separation-complete. If timing were not restarted there, a break would be measured from the wrong origin. The stimulus holds the line passive for exactly 290 ticks, which is past end-of-frame but short of separation. It then raises the line and expects the break on tick 239 from that new edge, with no break on tick 238. A long active stretch of more than 511 ticks, followed by an equally long passive one, drives the counter into saturation. This shows that no event repeats.

// File: rtl/vpw_sym_pkg.sv
package vpw_sym_pkg;

    typedef struct packed {
        logic eod;
        logic eof;
        logic ifs;
        logic brk;
    } sym_ev_t;

    typedef struct packed {
        logic    line_prev;
        logic    in_period;
        logic    ifs_done;
        logic    brk_flag;
        sym_ev_t ev;
    } cls_state_t;

endpackage

// File: rtl/vpw_line_sync.sv
module vpw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/vpw_width_counter.sv
module vpw_width_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          adv
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        adv   = tick && !restart && (cnt_q != CMAX);
        cnt_d = cnt_q;
        if (restart)  cnt_d = '0;
        else if (adv) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R9: the counter never wraps past its ceiling
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX) |=> (cnt_q == CMAX || cnt_q == '0));
endmodule

// File: rtl/vpw_symbol_timer.sv
module vpw_symbol_timer
    import vpw_sym_pkg::*;
#(
    parameter int CW       = 9,
    parameter int SYNC_FF  = 2,
    parameter int EOD_US   = 200,
    parameter int EOF_US   = 280,
    parameter int IFS_US   = 300,
    parameter int BRK_US   = 239
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic us_tick,
    input  logic tx_busy,
    input  logic brk_clr,
    output logic eod_pulse,
    output logic eof_pulse,
    output logic ifs_pulse,
    output logic brk_pulse,
    output logic brk_flag,
    output logic tx_permit,
    output logic tx_abort
);
    localparam logic [CW-1:0] EOD_T = CW'(EOD_US);
    localparam logic [CW-1:0] EOF_T = CW'(EOF_US);
    localparam logic [CW-1:0] IFS_T = CW'(IFS_US);
    localparam logic [CW-1:0] BRK_T = CW'(BRK_US);

    logic          line_s;
    logic          edge_seen, rise_seen;
    logic          adv;
    logic [CW-1:0] cnt, nxt;
    logic          pas_step, act_step;
    cls_state_t    st_d, st_q;

    vpw_line_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s)
    );

    vpw_width_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(edge_seen), .tick(us_tick),
        .cnt(cnt), .adv(adv)
    );

    always_comb begin
        edge_seen = line_s ^ st_q.line_prev;
        rise_seen = edge_seen && line_s;
        nxt       = cnt + 1'b1;
        pas_step  = adv && st_q.in_period && !line_s;
        act_step  = adv && st_q.in_period && line_s;

        st_d           = st_q;
        st_d.line_prev = line_s;
        st_d.in_period = st_q.in_period || edge_seen;
        st_d.ev.eod    = pas_step && (nxt == EOD_T);
        st_d.ev.eof    = pas_step && (nxt == EOF_T);
        st_d.ev.ifs    = pas_step && (nxt == IFS_T);
        st_d.ev.brk    = act_step && (nxt == BRK_T);

        if (rise_seen)        st_d.ifs_done = 1'b0;
        else if (st_d.ev.ifs) st_d.ifs_done = 1'b1;

        if (st_d.ev.brk)  st_d.brk_flag = 1'b1;
        else if (brk_clr) st_d.brk_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ifs_done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign eod_pulse = st_q.ev.eod;
    assign eof_pulse = st_q.ev.eof;
    assign ifs_pulse = st_q.ev.ifs;
    assign brk_pulse = st_q.ev.brk;
    assign brk_flag  = st_q.brk_flag;
    assign tx_permit = st_q.ifs_done && !line_s;
    assign tx_abort  = st_q.brk_flag && line_s && tx_busy;

    // R9: thresholds are distinct, so at most one event per cycle
    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eod_pulse, eof_pulse, ifs_pulse, brk_pulse}));
    // R6: a break pulse comes with the flag set
    a_r6_brk_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> brk_flag);
    // R7: a clear without a new break drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !st_d.ev.brk) |=> !brk_flag);
    // R4: separation-complete leaves the permission armed
    a_r4_ifs_arms: assert property (@(posedge clk) disable iff (!rst_n)
        ifs_pulse |-> st_q.ifs_done);
    // R8: once the flag falls, no abort remains
    a_r8_abort_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_flag) |-> !tx_abort);
endmodule

// File: tb/vpw_symbol_timer_test.sv
`timescale 1ns/1ps
module vpw_symbol_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0, us_tick = 1'b0, tx_busy = 1'b0, brk_clr = 1'b0;
    logic eod_pulse, eof_pulse, ifs_pulse, brk_pulse, brk_flag, tx_permit, tx_abort;

    int errors = 0;
    int checks = 0;
    int tick_idx = 0;
    bit finished = 0;

    typedef struct {
        int    kind;
        int    idx;
        string req;
    } exp_t;
    exp_t exq[$];
    string kname[4] = '{"EOD", "EOF", "IFS", "BRK"};

    always #2.5 clk = ~clk;

    vpw_symbol_timer uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .us_tick(us_tick),
        .tx_busy(tx_busy), .brk_clr(brk_clr),
        .eod_pulse(eod_pulse), .eof_pulse(eof_pulse), .ifs_pulse(ifs_pulse),
        .brk_pulse(brk_pulse), .brk_flag(brk_flag), .tx_permit(tx_permit),
        .tx_abort(tx_abort)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int idx, input string req);
        exp_t e;
        e.kind = kind; e.idx = idx; e.req = req;
        exq.push_back(e);
    endtask

    task automatic seen_ev(input int kind);
        exp_t e;
        checks++;
        if (exq.size() == 0) begin
            errors++;
            $display("FAIL R9: unexpected %s at tick %0d actual=1 expected=0",
                     kname[kind], tick_idx);
        end else begin
            e = exq.pop_front();
            if (e.kind != kind || e.idx != tick_idx) begin
                errors++;
                $display("FAIL %s: actual=%s@%0d expected=%s@%0d",
                         e.req, kname[kind], tick_idx, kname[e.kind], e.idx);
            end
        end
    endtask

    task automatic queue_empty(input string req);
        chk(req, exq.size(), 0);
        exq.delete();
    endtask

    // monitor: compares produced events against the scoreboard queue
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (eod_pulse) seen_ev(0);
            if (eof_pulse) seen_ev(1);
            if (ifs_pulse) seen_ev(2);
            if (brk_pulse) seen_ev(3);
        end
    end

    task automatic set_line(input logic v);
        @(negedge clk);
        line_in = v;
        tick_idx = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            us_tick = 1'b1;
            tick_idx++;
            @(negedge clk);
            us_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 eod", eod_pulse, 0);
        chk("R1 brk_pulse", brk_pulse, 0);
        chk("R1 brk_flag", brk_flag, 0);
        chk("R1 permit", tx_permit, 1);
        chk("R1 abort", tx_abort, 0);

        // R10: ticks with no transition give nothing
        ticks(350);
        queue_empty("R10");

        // R2 R3 R4: plain frame end
        set_line(1'b1);
        chk("R4 permit low while active", tx_permit, 0);
        ticks(50);
        set_line(1'b0);
        expect_ev(0, 200, "R2");
        expect_ev(1, 280, "R3");
        expect_ev(2, 300, "R4");
        ticks(299);
        chk("R4 permit before ifs", tx_permit, 0);
        ticks(1);
        chk("R4 permit after ifs", tx_permit, 1);
        ticks(20);
        queue_empty("R4");

        // R3: in-frame response restarts the passive timing
        set_line(1'b1);
        ticks(20);
        set_line(1'b0);
        expect_ev(0, 200, "R2");
        ticks(220);
        set_line(1'b1);
        ticks(30);
        set_line(1'b0);
        expect_ev(0, 200, "R3 restart eod");
        expect_ev(1, 280, "R3 restart eof");
        expect_ev(2, 300, "R3 restart ifs");
        ticks(310);
        queue_empty("R3");

        // R5 R6 R8: edge during separation wait, then break
        set_line(1'b1);
        ticks(10);
        set_line(1'b0);
        expect_ev(0, 200, "R2");
        expect_ev(1, 280, "R3");
        ticks(290);
        chk("R4 permit inside wait", tx_permit, 0);
        tx_busy = 1'b1;
        set_line(1'b1);
        chk("R4 permit after early edge", tx_permit, 0);
        expect_ev(3, 239, "R6");
        ticks(238);
        chk("R5 no break before 239 from new edge", brk_flag, 0);
        chk("R8 no abort before break", tx_abort, 0);
        ticks(1);
        chk("R6 flag set", brk_flag, 1);
        chk("R8 abort", tx_abort, 1);
        ticks(300);
        queue_empty("R9 single break");
        @(negedge clk);
        tx_busy = 1'b0;
        #1;
        chk("R8 abort needs busy", tx_abort, 0);
        @(negedge clk);
        tx_busy = 1'b1;
        #1;
        chk("R8 abort busy again", tx_abort, 1);
        set_line(1'b0);
        chk("R8 abort needs active", tx_abort, 0);
        chk("R7 flag sticky", brk_flag, 1);
        set_line(1'b1);
        chk("R8 abort on active with flag", tx_abort, 1);
        @(negedge clk);
        brk_clr = 1'b1;
        @(negedge clk);
        brk_clr = 1'b0;
        chk("R7 cleared", brk_flag, 0);
        chk("R8 abort after clear", tx_abort, 0);

        // R6: 238 us active gives no break; R9 long passive saturates
        set_line(1'b0);
        set_line(1'b1);
        ticks(238);
        chk("R6 short active", brk_flag, 0);
        set_line(1'b0);
        expect_ev(0, 200, "R2");
        expect_ev(1, 280, "R3");
        expect_ev(2, 300, "R4");
        ticks(800);
        queue_empty("R9 single events");
        chk("R4 permit idle", tx_permit, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule